// File: doc/BRIEF.md
# Keyed Watchdog with Lockable Control

This block is a watchdog timer that sits inside a board management controller. A host reaches it through a byte-wide register port with three locations: a control byte, a timeout byte holding the period in whole seconds, and a refresh location. Software selects a period, reloads the counter by writing a fixed key value, and then turns on one of two modes. The first mode is plain supervision. The second is recovery supervision, in which an expiry also asks for the failsafe boot image.

A prescaler divides the system clock down to a one-second tick, and that tick decrements the counter. When the counter reaches zero while the watchdog is enabled, the block does whatever software has armed. It can emit a fixed-length system reset request, pull an active-low timeout pin low, and, in recovery mode, raise a failsafe-boot flag. The pin and the flag stay set until the block itself is reset.

A lock bit freezes the mode bits, the lock bit itself and the period until the next reset. This keeps supervision running even if later code misbehaves.

Top module: `wdk_top`

## Requirements
- R1: After reset the control byte and the timeout byte read 0, the watchdog is disabled, `sys_rst_req` is 0, `timeout_n` is 1 and `failsafe_boot` is 0.
- R2: `rdata` is combinational from `addr`. Offset 0x00 returns the control byte. Bit 0 of the control byte is normal enable, bit 1 is recovery enable, bit 2 is lock, bit 6 is reset action and bit 7 is pin action, and all other bits read 0. Offset 0x01 returns the timeout byte. Offset 0x02 and any unused offset return 0.
- R3: A write of 0x6B to offset 0x02 reloads the counter from the timeout byte and restarts the prescaler. A write of any other value there changes neither the counter nor the prescaler.
- R4: With the counter loaded to T (T ≥ 1) and the watchdog enabled at a clock edge, expiry outputs change exactly T*TICK_DIV+1 edges later and not before. The reference edge is either the write edge of the enable or the write edge of a key refresh while enabled.
- R5: Enabling with a counter value of 0 causes expiry outputs one edge after the enabling write.
- R6: While both enable bits are 0, the counter does not advance and no expiry occurs.
- R7: An expiry while recovery enable is set raises `failsafe_boot`, which stays 1 until reset. An expiry in normal mode alone leaves it 0.
- R8: An expiry with the pin action bit set drives `timeout_n` to 0 until reset. With that bit clear, `timeout_n` stays 1.
- R9: An expiry with the reset action bit set produces a `sys_rst_req` pulse exactly RST_LEN cycles long. With that bit clear there is no pulse.
- R10: While lock is set, writes to the enable bits, the lock bit and the timeout byte are ignored, while the two action bits remain writable. Only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sys_rst_req | output | 1 | System reset request pulse |
| timeout_n | output | 1 | Active-low sticky timeout pin |
| failsafe_boot | output | 1 | Sticky request to boot the failsafe image |

## Verification
The bench builds the block with TICK_DIV=4 and RST_LEN=5, so one "second" lasts four clocks. This lets it sweep every period from 0 to 5 against both modes and all four combinations of the action bits, and check every expiry edge cycle-exactly. The short reset pulse allows the bench to count its full width in each case. The same small configuration keeps the timing of a mid-period key refresh, a wrong key, a disable before expiry and the lock rules within a few dozen cycles each.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam int OFS_CTRL = 0;
  localparam int OFS_TMO  = 1;
  localparam int OFS_KICK = 2;

  localparam logic [7:0] KICK_KEY = 8'h6B;

  typedef struct packed {
    logic pin_act;
    logic rst_act;
    logic lock;
    logic recov_en;
    logic norm_en;
  } ctrl_t;

  // Byte image of the control register as seen by a read.
  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    return {c.pin_act, c.rst_act, 3'b000, c.lock, c.recov_en, c.norm_en};
  endfunction

  // New control state after a write; locked fields keep their value.
  function automatic ctrl_t ctrl_write(input ctrl_t cur, input logic [7:0] wd);
    ctrl_t n;
    n.pin_act = wd[7];
    n.rst_act = wd[6];
    if (cur.lock) begin
      n.lock     = 1'b1;
      n.recov_en = cur.recov_en;
      n.norm_en  = cur.norm_en;
    end else begin
      n.lock     = wd[2];
      n.recov_en = wd[1];
      n.norm_en  = wd[0];
    end
    return n;
  endfunction

  // Prescaler wrap test.
  function automatic logic at_last(input int unsigned value, input int unsigned period);
    return value == period - 1;
  endfunction

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output ctrl_t             ctrl_q,
  output logic [7:0]        tmo_q,
  output logic              kick_ok,
  output logic [7:0]        rdata
);

  logic sel_ctrl, sel_tmo, sel_kick;

  assign sel_ctrl = addr == ADDR_W'(OFS_CTRL);
  assign sel_tmo  = addr == ADDR_W'(OFS_TMO);
  assign sel_kick = addr == ADDR_W'(OFS_KICK);

  assign kick_ok = wr_en && sel_kick && (wdata == KICK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tmo_q  <= '0;
    end else if (wr_en) begin
      if (sel_ctrl) ctrl_q <= ctrl_write(ctrl_q, wdata);
      if (sel_tmo && !ctrl_q.lock) tmo_q <= wdata;
    end
  end

  always_comb begin
    if (sel_ctrl)     rdata = ctrl_to_byte(ctrl_q);
    else if (sel_tmo) rdata = tmo_q;
    else              rdata = 8'h00;
  end

endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler
  import wdk_pkg::*;
#(
  parameter int TICK_DIV = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap = at_last(int'(cnt_q), TICK_DIV);
  assign tick = run && !restart && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else if (wrap)             cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       tick,
  output logic [7:0] count_q,
  output logic       expire
);

  logic fired_q;

  assign expire = run && (count_q == 8'd0) && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (run && tick && count_q != 8'd0) begin
      count_q <= count_q - 8'd1;
    end
  end

  // One expiry per arming; re-armed by a reload or by disabling.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fired_q <= 1'b0;
    else if (load)   fired_q <= 1'b0;
    else if (expire) fired_q <= 1'b1;
    else if (!run)   fired_q <= 1'b0;
  end

endmodule

// File: rtl/wdk_actions.sv
module wdk_actions #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rst_act,
  input  logic pin_act,
  input  logic recov,
  output logic sys_rst_req,
  output logic timeout_n,
  output logic failsafe_boot
);

  localparam int RW = $clog2(RST_LEN + 1);

  logic [RW-1:0] pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pulse_q <= '0;
    else if (expire && rst_act) pulse_q <= RW'(RST_LEN);
    else if (pulse_q != '0)     pulse_q <= pulse_q - 1'b1;
  end

  assign sys_rst_req = pulse_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_n     <= 1'b1;
      failsafe_boot <= 1'b0;
    end else if (expire) begin
      if (pin_act) timeout_n     <= 1'b0;
      if (recov)   failsafe_boot <= 1'b1;
    end
  end

endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TICK_DIV = 1000000,
  parameter int RST_LEN  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              sys_rst_req,
  output logic              timeout_n,
  output logic              failsafe_boot
);

  ctrl_t      ctrl_q;
  logic [7:0] tmo_q;
  logic [7:0] count_q;
  logic       kick_ok;
  logic       tick;
  logic       active;
  logic       expire_evt;
  logic       lock_q, rst_act_q, pin_act_q, recov_q;

  assign active    = ctrl_q.norm_en || ctrl_q.recov_en;
  assign lock_q    = ctrl_q.lock;
  assign rst_act_q = ctrl_q.rst_act;
  assign pin_act_q = ctrl_q.pin_act;
  assign recov_q   = ctrl_q.recov_en;

  wdk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .tmo_q(tmo_q), .kick_ok(kick_ok), .rdata(rdata)
  );

  wdk_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(kick_ok), .tick(tick)
  );

  wdk_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(active), .load(kick_ok),
    .load_val(tmo_q), .tick(tick), .count_q(count_q), .expire(expire_evt)
  );

  wdk_actions #(.RST_LEN(RST_LEN)) u_act (
    .clk(clk), .rst_n(rst_n), .expire(expire_evt),
    .rst_act(rst_act_q), .pin_act(pin_act_q), .recov(recov_q),
    .sys_rst_req(sys_rst_req), .timeout_n(timeout_n), .failsafe_boot(failsafe_boot)
  );

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       kick_ok,
  input logic       expire_evt,
  input logic       lock_q,
  input logic       rst_act_q,
  input logic       pin_act_q,
  input logic       recov_q,
  input logic [7:0] tmo_q,
  input logic [7:0] count_q,
  input logic       sys_rst_req,
  input logic       timeout_n,
  input logic       failsafe_boot
);

  assert_kick_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> count_q == $past(tmo_q));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !kick_ok) |=> $stable(count_q));

  assert_failsafe_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && recov_q) |=> failsafe_boot);

  assert_failsafe_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe_boot |=> failsafe_boot);

  assert_pin_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && pin_act_q) |=> !timeout_n);

  assert_pin_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !timeout_n |=> !timeout_n);

  assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && rst_act_q) |=> sys_rst_req);

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(expire_evt && rst_act_q));

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_lock_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(tmo_q));

endmodule

bind wdk_top wdk_checker u_wdk_checker (
  .clk(clk), .rst_n(rst_n), .active(active), .kick_ok(kick_ok),
  .expire_evt(expire_evt), .lock_q(lock_q), .rst_act_q(rst_act_q),
  .pin_act_q(pin_act_q), .recov_q(recov_q), .tmo_q(tmo_q),
  .count_q(count_q), .sys_rst_req(sys_rst_req), .timeout_n(timeout_n),
  .failsafe_boot(failsafe_boot)
);

// File: tb/test_wdk_top.sv
module test_wdk_top;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int RLEN       = 5;
  localparam int LIMIT      = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sys_rst_req, timeout_n, failsafe_boot;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdk_top #(.ADDR_W(8), .TICK_DIV(TDIV), .RST_LEN(RLEN)) i_wdk_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sys_rst_req(sys_rst_req), .timeout_n(timeout_n),
    .failsafe_boot(failsafe_boot)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset;
    rst_n = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic int outs();
    return {29'd0, sys_rst_req, timeout_n, failsafe_boot};
  endfunction

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] cv;
    int highs;

    // R1: reset state
    apply_reset();
    rd(8'h00, v); check("R1 ctrl after reset", v, 0);
    rd(8'h01, v); check("R1 timeout after reset", v, 0);
    check("R1 outputs after reset", outs(), 3'b010);

    // R2: read map and unimplemented bits
    wr(8'h00, 8'h78);
    rd(8'h00, v); check("R2 ctrl unimplemented bits", v, 8'h40);
    wr(8'h01, 8'hA5);
    rd(8'h01, v); check("R2 timeout readback", v, 8'hA5);
    rd(8'h02, v); check("R2 kick reads zero", v, 0);
    rd(8'h03, v); check("R2 unused offset", v, 0);

    // R4 R5 R7 R8 R9: sweep period, mode and action bits
    for (int t = 0; t < 6; t++) begin
      for (int m = 0; m < 2; m++) begin
        for (int act = 0; act < 4; act++) begin
          apply_reset();
          cv = (m == 1 ? 8'h02 : 8'h01) | (act[0] ? 8'h40 : 8'h00) | (act[1] ? 8'h80 : 8'h00);
          wr(8'h01, 8'(t));
          wr(8'h02, 8'h6B);
          wr(8'h00, cv);
          repeat (t * TDIV) @(negedge clk);
          check(t == 0 ? "R5 quiet at enable edge" : "R4 quiet before expiry", outs(), 3'b010);
          @(negedge clk);
          highs = int'(sys_rst_req);
          check(t == 0 ? "R5 pin at expiry" : "R8 pin at expiry", int'(timeout_n), act[1] ? 0 : 1);
          check("R7 failsafe at expiry", int'(failsafe_boot), m);
          check(t == 0 ? "R5 reset req at expiry" : "R4 reset req at expiry", int'(sys_rst_req), act[0]);
          repeat (RLEN + 3) begin
            @(negedge clk);
            highs += int'(sys_rst_req);
          end
          check("R9 pulse length", highs, act[0] ? RLEN : 0);
          check("R7 failsafe sticky", int'(failsafe_boot), m);
          check("R8 pin sticky", int'(timeout_n), act[1] ? 0 : 1);
        end
      end
    end

    // R3: wrong key has no effect
    apply_reset();
    wr(8'h01, 8'd3); wr(8'h02, 8'h6B); wr(8'h00, 8'h81);
    repeat (6) @(negedge clk);
    wr(8'h02, 8'h6A);
    repeat (5) @(negedge clk);
    check("R3 wrong key quiet", int'(timeout_n), 1);
    @(negedge clk);
    check("R3 wrong key keeps schedule", int'(timeout_n), 0);

    // R3: valid key mid-period restarts the full period
    apply_reset();
    wr(8'h01, 8'd3); wr(8'h02, 8'h6B); wr(8'h00, 8'h81);
    repeat (6) @(negedge clk);
    wr(8'h02, 8'h6B);
    repeat (12) @(negedge clk);
    check("R3 refresh postpones expiry", int'(timeout_n), 1);
    @(negedge clk);
    check("R3 refresh expiry time", int'(timeout_n), 0);

    // R6: disabling stops the watchdog
    apply_reset();
    wr(8'h01, 8'd2); wr(8'h02, 8'h6B); wr(8'h00, 8'h81);
    repeat (3) @(negedge clk);
    wr(8'h00, 8'h80);
    repeat (40) @(negedge clk);
    check("R6 no expiry while disabled", outs(), 3'b010);
    rd(8'h00, v); check("R6 ctrl disabled", v, 8'h80);

    // R10: lock behaviour
    apply_reset();
    wr(8'h01, 8'd10);
    wr(8'h00, 8'h45);
    rd(8'h00, v); check("R10 locked ctrl", v, 8'h45);
    wr(8'h00, 8'h00);
    rd(8'h00, v); check("R10 lock keeps enable and lock", v, 8'h05);
    wr(8'h00, 8'h82);
    rd(8'h00, v); check("R10 action bits writable", v, 8'h85);
    wr(8'h01, 8'd3);
    rd(8'h01, v); check("R10 timeout frozen", v, 8'd10);
    apply_reset();
    rd(8'h00, v); check("R10 reset clears lock", v, 0);

    finish_run();
  end

endmodule